// File: doc/BRIEF.md
# Transmit Descriptor Ring Sequencer

This block steps through a ring of transmit descriptors kept in a register-mapped table. Each table entry holds two 32-bit words. The first is a control and status word, and the second is the buffer start address. When software marks the current entry ready, the sequencer captures the entry. It then presents the buffer address, the frame length and the pad and CRC options to a frame transmitter, using a request that stays high until the transmitter returns a done pulse with nine bits of outcome status.

When the frame finishes, the sequencer writes the outcome bits back into the status word and drops the ready flag, so software can see that the descriptor is free again. If the entry asked for an interrupt, the sequencer also latches a good-frame or bad-frame flag. It then moves to the next entry. It returns to entry 0 after an entry flagged as last, or after the final entry of the ring.

A host port writes and reads the table, the ring-size register and the interrupt flags. The ring size is programmable, so one table can be shared with a receive ring that sits above the transmit entries. The transmitter, the DMA engine and the line interface are outside this block.

Top module: `txbd_sequencer`

## Requirements
- R1: After reset, the ring-size register (byte offset 0x20) reads 64, the interrupt flag register (byte offset 0x04) reads 0, `irq_o` is low and `tx_req` is low.
- R2: A host write to offset 0x20 stores the written value, except that any value above 128 is stored as 128.
- R3: The status word of table entry i lives at byte offset 0x400 + 8*i and its address word at 0x400 + 8*i + 4. Both can be written and read back by the host.
- R4: When transmit is enabled and the current entry's status bit 15 (ready) is set, `tx_req` rises. It carries `tx_len` = status bits 31:16, `tx_addr` = the address word, `tx_pad` = bit 12 and `tx_crc` = bit 11. All of these stay unchanged until `tx_done` is seen.
- R5: While the current entry is not ready, no request is made and the sequencer stays on that entry, even if later entries are ready.
- R6: On `tx_done`, the entry's status word becomes the captured word with bit 15 cleared and bits 8:0 replaced by `tx_stat`. Bits 8:0 carry underrun in bit 8, retry count in bits 7:4, retry limit in bit 3, late collision in bit 2, deferred in bit 1 and carrier lost in bit 0.
- R7: On completion of an entry with bit 14 (interrupt enable) set, flag bit 0 is set for a good frame. Flag bit 1 is set if any of `tx_stat` bits 8, 3, 2 or 0 is high. Without bit 14, no flag is set. `irq_o` is the OR of both flags. Writing 1 to a flag bit clears it.
- R8: After an entry with status bit 13 (last) set, or after entry ring-size minus 1, the next entry is 0. Otherwise the next entry is the current one plus 1.
- R9: When `tx_en` is low, no new frame is started. A frame already in progress keeps its request until done, and the sequencer then returns to entry 0.
- R10: With the ring-size register at 0, no frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | 12 | Host write byte address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | 12 | Host read byte address |
| host_rdata | output | 32 | Host read data (combinational) |
| tx_en | input | 1 | Transmit enable |
| tx_req | output | 1 | Frame request to the transmitter |
| tx_len | output | 16 | Frame length in bytes |
| tx_addr | output | 32 | Buffer start address |
| tx_pad | output | 1 | Pad short frames |
| tx_crc | output | 1 | Append CRC |
| tx_done | input | 1 | Frame finished pulse |
| tx_stat | input | 9 | Frame outcome bits |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check four properties on every cycle. A request holds its address and length until done. A disabled sequencer with no frame in flight sits on entry 0. A zero-size ring never starts a frame. A rising interrupt always follows a done pulse. The assertions also check that a completed entry flagged as last sends the index to 0, and that the ring size never exceeds its limit. Only the bench scenarios can show the rest: the exact write-back word, the choice between the good and error flags, the refusal to skip past a non-ready entry, and the order in which entries are served after a wrap or a disable.

// File: rtl/txbd_pkg.sv
package txbd_pkg;
   localparam int BIT_READY = 15;
   localparam int BIT_IRQ   = 14;
   localparam int BIT_LAST  = 13;
   localparam int BIT_PAD   = 12;
   localparam int BIT_CRC   = 11;
   localparam int OUT_W     = 9;
   // underrun(8), retry limit(3), late collision(2), carrier lost(0)
   localparam logic [OUT_W-1:0] FAIL_MASK = 9'h10D;

   typedef enum logic {
      SEQ_POLL,
      SEQ_BUSY
   } seq_state_e;
endpackage

// File: rtl/txbd_table.sv
module txbd_table #(
   parameter int ENTRIES = 128,
   localparam int WORDS  = 2 * ENTRIES,
   localparam int WIW    = $clog2(WORDS),
   localparam int EIW    = $clog2(ENTRIES)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           host_we,
   input  logic [WIW-1:0] host_widx,
   input  logic [31:0]    host_wdata,
   input  logic [WIW-1:0] host_ridx,
   output logic [31:0]    host_rword,
   input  logic [EIW-1:0] seq_ridx,
   output logic [31:0]    seq_stat,
   output logic [31:0]    seq_addr,
   input  logic           seq_we,
   input  logic [EIW-1:0] seq_widx,
   input  logic [31:0]    seq_wdata
);
   logic [31:0] mem [WORDS];

   generate
      for (genvar w = 0; w < WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               mem[w] <= '0;
            else if (seq_we && (w % 2 == 0) && (WIW'(w) == {seq_widx, 1'b0}))
               mem[w] <= seq_wdata;
            else if (host_we && (host_widx == WIW'(w)))
               mem[w] <= host_wdata;
         end
      end
   endgenerate

   assign host_rword = mem[host_ridx];
   assign seq_stat   = mem[{seq_ridx, 1'b0}];
   assign seq_addr   = mem[{seq_ridx, 1'b1}];
endmodule

// File: rtl/txbd_ring_cnt.sv
module txbd_ring_cnt #(
   parameter int MAX_TX    = 128,
   parameter int RESET_CNT = 64,
   localparam int CW       = $clog2(MAX_TX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [31:0]   wdata,
   output logic [CW-1:0] ring_cnt
);
   generate
      if (RESET_CNT > MAX_TX) begin : g_bad_reset
         $error("RESET_CNT exceeds MAX_TX");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ring_cnt <= CW'(RESET_CNT);
      else if (we)
         ring_cnt <= (wdata > 32'(MAX_TX)) ? CW'(MAX_TX) : wdata[CW-1:0];
   end

   AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ring_cnt <= CW'(MAX_TX)); // R2
endmodule

// File: rtl/txbd_seq.sv
module txbd_seq
   import txbd_pkg::*;
#(
   parameter int MAX_TX = 128,
   localparam int IW    = $clog2(MAX_TX),
   localparam int CW    = $clog2(MAX_TX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic [CW-1:0]    ring_cnt,
   output logic [IW-1:0]    rd_idx,
   input  logic [31:0]      stat_word,
   input  logic [31:0]      addr_word,
   output logic             tx_req,
   output logic [15:0]      tx_len,
   output logic [31:0]      tx_addr,
   output logic             tx_pad,
   output logic             tx_crc,
   input  logic             tx_done,
   input  logic [OUT_W-1:0] tx_stat,
   output logic             wb_we,
   output logic [IW-1:0]    wb_idx,
   output logic [31:0]      wb_data,
   output logic             evt_good,
   output logic             evt_bad
);
   seq_state_e  state;
   logic [IW-1:0] cur_idx;
   logic [31:0] cap_stat, cap_addr;
   logic        launch, finish, failed;
   logic [CW-1:0] next_lin;
   logic [IW-1:0] next_idx;

   assign launch   = (state == SEQ_POLL) && tx_en && (ring_cnt != '0) && stat_word[BIT_READY];
   assign finish   = (state == SEQ_BUSY) && tx_done;
   assign failed   = |(tx_stat & FAIL_MASK);
   assign next_lin = CW'(cur_idx) + CW'(1);

   always_comb begin
      if (!tx_en || cap_stat[BIT_LAST] || (next_lin >= ring_cnt))
         next_idx = '0;
      else
         next_idx = cur_idx + IW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_POLL;
         cur_idx  <= '0;
         cap_stat <= '0;
         cap_addr <= '0;
      end else if (state == SEQ_POLL) begin
         if (!tx_en)
            cur_idx <= '0;
         else if (launch) begin
            state    <= SEQ_BUSY;
            cap_stat <= stat_word;
            cap_addr <= addr_word;
         end
      end else if (tx_done) begin
         state   <= SEQ_POLL;
         cur_idx <= next_idx;
      end
   end

   assign rd_idx   = cur_idx;
   assign tx_req   = (state == SEQ_BUSY);
   assign tx_len   = cap_stat[31:16];
   assign tx_addr  = cap_addr;
   assign tx_pad   = cap_stat[BIT_PAD];
   assign tx_crc   = cap_stat[BIT_CRC];
   assign wb_we    = finish;
   assign wb_idx   = cur_idx;
   assign wb_data  = {cap_stat[31:16], 1'b0, cap_stat[14:9], tx_stat};
   assign evt_good = finish && cap_stat[BIT_IRQ] && !failed;
   assign evt_bad  = finish && cap_stat[BIT_IRQ] && failed;

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && !tx_done) |=> (tx_req && $stable(tx_addr) && $stable(tx_len))); // R4
   AST_OFF_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !tx_req) |=> (cur_idx == '0)); // R9
   AST_LAST_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_req && tx_done && cap_stat[BIT_LAST]) |=> (cur_idx == '0)); // R8
   AST_EMPTY_RING: assert property (@(posedge clk) disable iff (!rst_n)
      ((ring_cnt == '0) && !tx_req) |=> !tx_req); // R10
endmodule

// File: rtl/txbd_sequencer.sv
module txbd_sequencer
   import txbd_pkg::*;
#(
   parameter int          MAX_TX      = 128,
   parameter int          TBL_ENTRIES = 128,
   parameter int          RESET_CNT   = 64,
   parameter int          AW          = 12,
   parameter logic [11:0] TBL_BASE    = 12'h400,
   parameter logic [11:0] CNT_OFS     = 12'h020,
   parameter logic [11:0] FLAG_OFS    = 12'h004
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [AW-1:0]    host_waddr,
   input  logic [31:0]      host_wdata,
   input  logic [AW-1:0]    host_raddr,
   output logic [31:0]      host_rdata,
   input  logic             tx_en,
   output logic             tx_req,
   output logic [15:0]      tx_len,
   output logic [31:0]      tx_addr,
   output logic             tx_pad,
   output logic             tx_crc,
   input  logic             tx_done,
   input  logic [OUT_W-1:0] tx_stat,
   output logic             irq_o
);
   localparam int WIW    = $clog2(2 * TBL_ENTRIES);
   localparam int EIW    = $clog2(TBL_ENTRIES);
   localparam int IW     = $clog2(MAX_TX);
   localparam int CW     = $clog2(MAX_TX + 1);
   localparam int TBL_SZ = 8 * TBL_ENTRIES;

   generate
      if (MAX_TX > TBL_ENTRIES) begin : g_bad_split
         $error("MAX_TX exceeds table size");
      end
      if (int'(TBL_BASE) + TBL_SZ > (1 << AW)) begin : g_bad_map
         $error("table does not fit address space");
      end
   endgenerate

   logic [AW-1:0]  w_ofs, r_ofs;
   logic           w_tbl, r_tbl;
   logic [WIW-1:0] w_idx, r_idx;
   logic [31:0]    tbl_rword, seq_stat, seq_addr, wb_data;
   logic [CW-1:0]  ring_cnt;
   logic [IW-1:0]  rd_idx, wb_idx;
   logic           wb_we, evt_good, evt_bad;
   logic [1:0]     flags, flag_clr;

   assign w_ofs = host_waddr - AW'(TBL_BASE);
   assign r_ofs = host_raddr - AW'(TBL_BASE);
   assign w_tbl = (host_waddr >= AW'(TBL_BASE)) && (32'(w_ofs) < 32'(TBL_SZ));
   assign r_tbl = (host_raddr >= AW'(TBL_BASE)) && (32'(r_ofs) < 32'(TBL_SZ));
   assign w_idx = WIW'(w_ofs >> 2);
   assign r_idx = WIW'(r_ofs >> 2);

   txbd_table #(.ENTRIES(TBL_ENTRIES)) u_table (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_we && w_tbl), .host_widx(w_idx), .host_wdata(host_wdata),
      .host_ridx(r_idx), .host_rword(tbl_rword),
      .seq_ridx(EIW'(rd_idx)), .seq_stat(seq_stat), .seq_addr(seq_addr),
      .seq_we(wb_we), .seq_widx(EIW'(wb_idx)), .seq_wdata(wb_data)
   );

   txbd_ring_cnt #(.MAX_TX(MAX_TX), .RESET_CNT(RESET_CNT)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .we(host_we && (host_waddr == AW'(CNT_OFS))), .wdata(host_wdata),
      .ring_cnt(ring_cnt)
   );

   txbd_seq #(.MAX_TX(MAX_TX)) u_seq (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ring_cnt(ring_cnt),
      .rd_idx(rd_idx), .stat_word(seq_stat), .addr_word(seq_addr),
      .tx_req(tx_req), .tx_len(tx_len), .tx_addr(tx_addr),
      .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat),
      .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data),
      .evt_good(evt_good), .evt_bad(evt_bad)
   );

   // flags: new events win over a same-cycle clear
   assign flag_clr = (host_we && (host_waddr == AW'(FLAG_OFS))) ? host_wdata[1:0] : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= 2'b00;
      else
         flags <= {evt_bad, evt_good} | (flags & ~flag_clr);
   end

   assign irq_o = |flags;

   always_comb begin
      if (r_tbl)
         host_rdata = tbl_rword;
      else if (host_raddr == AW'(CNT_OFS))
         host_rdata = 32'(ring_cnt);
      else if (host_raddr == AW'(FLAG_OFS))
         host_rdata = {30'b0, flags};
      else
         host_rdata = '0;
   end

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(tx_done)); // R7
endmodule

// File: tb/txbd_sequencer_tb_top.sv
module txbd_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_we = 1'b0;
   logic [11:0] host_waddr = '0;
   logic [31:0] host_wdata = '0;
   logic [11:0] host_raddr = '0;
   logic [31:0] host_rdata;
   logic        tx_en = 1'b1;
   logic        tx_req;
   logic [15:0] tx_len;
   logic [31:0] tx_addr;
   logic        tx_pad, tx_crc;
   logic        tx_done = 1'b0;
   logic [8:0]  tx_stat = '0;
   logic        irq_o;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   txbd_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_waddr(host_waddr),
      .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
      .tx_en(tx_en), .tx_req(tx_req), .tx_len(tx_len), .tx_addr(tx_addr),
      .tx_pad(tx_pad), .tx_crc(tx_crc), .tx_done(tx_done), .tx_stat(tx_stat),
      .irq_o(irq_o)
   );

   function automatic logic [31:0] mk(input int len, input bit rdy, input bit irq,
                                      input bit last, input bit pad, input bit crc);
      return {16'(len), rdy, irq, last, pad, crc, 11'b0};
   endfunction

   function automatic logic [11:0] st_a(input int i); return 12'(12'h400 + 8 * i); endfunction
   function automatic logic [11:0] ad_a(input int i); return 12'(12'h404 + 8 * i); endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hw(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      host_we = 1'b1; host_waddr = a; host_wdata = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic hr(input logic [11:0] a, output logic [31:0] d);
      host_raddr = a;
      #1 d = host_rdata;
   endtask

   task automatic wait_req(input string req, input logic [31:0] exp_addr);
      bit seen = 0;
      for (int k = 0; k < 40 && !seen; k++) begin
         @(negedge clk);
         if (tx_req) seen = 1;
      end
      chk(req, {31'b0, seen}, 32'd1);
      chk(req, tx_addr, exp_addr);
   endtask

   task automatic no_req(input string req, input int n);
      bit any = 0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (tx_req) any = 1;
      end
      chk(req, {31'b0, any}, 32'd0);
   endtask

   task automatic finish_frame(input logic [8:0] st);
      @(negedge clk);
      tx_done = 1'b1; tx_stat = st;
      @(negedge clk);
      tx_done = 1'b0; tx_stat = '0;
   endtask

   task automatic test_reset;
      logic [31:0] d;
      hr(12'h020, d); chk("R1 ring size", d, 32'd64);
      hr(12'h004, d); chk("R1 flags", d, 32'd0);
      chk("R1 irq", {31'b0, irq_o}, 32'd0);
      chk("R1 req", {31'b0, tx_req}, 32'd0);
   endtask

   task automatic test_clamp;
      logic [31:0] d;
      hw(12'h020, 32'h200); hr(12'h020, d); chk("R2 clamp", d, 32'd128);
      hw(12'h020, 32'd128); hr(12'h020, d); chk("R2 at limit", d, 32'd128);
      hw(12'h020, 32'd4);   hr(12'h020, d); chk("R2 plain", d, 32'd4);
   endtask

   task automatic test_table;
      logic [31:0] d;
      hw(ad_a(2), 32'hDEAD_BEE0); hr(ad_a(2), d); chk("R3 addr word", d, 32'hDEAD_BEE0);
      hw(st_a(3), 32'h0000_0123); hr(st_a(3), d); chk("R3 status word", d, 32'h0000_0123);
      hw(st_a(3), 32'h0);
   endtask

   task automatic test_good_frame;
      logic [31:0] d;
      hw(ad_a(0), 32'h0000_1000);
      hw(st_a(0), mk(100, 1, 1, 0, 0, 1));
      wait_req("R4 launch", 32'h0000_1000);
      chk("R4 len", {16'b0, tx_len}, 32'd100);
      chk("R4 pad/crc", {30'b0, tx_pad, tx_crc}, 32'd1);
      repeat (5) @(negedge clk);
      chk("R4 held", {31'b0, tx_req}, 32'd1);
      finish_frame(9'h030);
      hr(st_a(0), d); chk("R6 writeback", d, mk(100, 0, 1, 0, 0, 1) | 32'h30);
      hr(12'h004, d); chk("R7 good flag", d, 32'd1);
      chk("R7 irq", {31'b0, irq_o}, 32'd1);
      hw(12'h004, 32'd1);
      hr(12'h004, d); chk("R7 clear", d, 32'd0);
      chk("R7 irq low", {31'b0, irq_o}, 32'd0);
   endtask

   task automatic test_stall_and_error;
      logic [31:0] d;
      hw(st_a(2), mk(200, 1, 0, 0, 0, 0));
      no_req("R5 no skip", 20);
      hw(ad_a(1), 32'h0000_00B1);
      hw(st_a(1), mk(60, 1, 1, 0, 1, 0));
      wait_req("R5 serves held entry", 32'h0000_00B1);
      chk("R4 pad", {30'b0, tx_pad, tx_crc}, 32'd2);
      finish_frame(9'h100);
      hr(12'h004, d); chk("R7 error flag", d, 32'd2);
      hr(st_a(1), d); chk("R6 error writeback", d, mk(60, 0, 1, 0, 1, 0) | 32'h100);
      hw(12'h004, 32'd2);
      wait_req("R8 advance", 32'hDEAD_BEE0);
      finish_frame(9'h004);
      hr(12'h004, d); chk("R7 no irq enable", d, 32'd0);
      hr(st_a(2), d); chk("R6 late collision", d, mk(200, 0, 0, 0, 0, 0) | 32'h4);
   endtask

   task automatic test_wrap;
      hw(ad_a(3), 32'h0000_00C3);
      hw(st_a(3), mk(64, 1, 0, 0, 0, 0));
      wait_req("R8 ring end", 32'h0000_00C3);
      finish_frame(9'h0);
      hw(ad_a(0), 32'h0000_00A0);
      hw(st_a(0), mk(64, 1, 0, 1, 0, 0));
      wait_req("R8 back to 0", 32'h0000_00A0);
      finish_frame(9'h0);
      hw(st_a(1), mk(64, 1, 0, 0, 0, 0));
      no_req("R8 last flag", 10);
      hw(st_a(0), mk(64, 1, 0, 0, 0, 0));
      wait_req("R8 after last", 32'h0000_00A0);
      finish_frame(9'h0);
      wait_req("R8 next", 32'h0000_00B1);
      finish_frame(9'h0);
   endtask

   task automatic test_disable;
      hw(ad_a(2), 32'h0000_00C2);
      hw(st_a(2), mk(80, 1, 0, 0, 0, 0));
      wait_req("R9 start", 32'h0000_00C2);
      @(negedge clk); tx_en = 1'b0;
      repeat (3) @(negedge clk);
      chk("R9 in flight", {31'b0, tx_req}, 32'd1);
      finish_frame(9'h0);
      hw(st_a(2), mk(80, 1, 0, 0, 0, 0));
      hw(st_a(0), mk(80, 1, 0, 0, 0, 0));
      no_req("R9 disabled", 10);
      @(negedge clk); tx_en = 1'b1;
      wait_req("R9 home", 32'h0000_00A0);
      finish_frame(9'h0);
   endtask

   task automatic test_empty_ring;
      hw(12'h020, 32'd0);
      hw(st_a(1), mk(90, 1, 0, 0, 0, 0));
      no_req("R10 zero ring", 10);
      hw(12'h020, 32'd4);
      wait_req("R10 restored", 32'h0000_00B1);
      finish_frame(9'h0);
      wait_req("R10 follow", 32'h0000_00C2);
      finish_frame(9'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_clamp();
      test_table();
      test_good_frame();
      test_stall_and_error();
      test_wrap();
      test_disable();
      test_empty_ring();
      repeat (3) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule